// File: doc/BRIEF.md
# Paged Byte Memory Write Engine

A synchronous model of the write path of a paged nonvolatile byte memory. A host drives active-low chip-select, write and output-enable strobes, an address and a data byte, all sampled on the clock. Each write strobe loads one byte into a page register, and each loaded byte sets a flag for its slot. Bytes may come in any order. The first byte of a load opens a page, and later bytes for another page are dropped.

When no byte has been accepted for `LOAD_TMO` cycles, the engine stops loading and starts a programming period of `PROG_CYC` cycles. The `busy` output is high for that whole period. At its last cycle only the flagged slots are copied into the storage array, and every other byte of the page keeps its old value. Strobes seen during the period are ignored.

A read strobe returns the stored byte one clock later with a valid flag. The array clears to zero on reset. Address width, page size and both timers are parameters. The full-size memory uses a 17-bit address with 128-byte pages, and the defaults are smaller so that the array stays light.

Top module: `pagewr_engine`

## Requirements
- R1: A write strobe is active while `ce_n`=0, `we_n`=0 and `oe_n`=1. The address is taken in the first clock where the strobe is active. The data is the `din` value of the last clock in which the strobe was active.
- R2: A strobe gated by `oe_n`=0, or by `ce_n`=1 with `we_n`=0, loads nothing and starts no programming period.
- R3: The first accepted byte opens the page `addr[ADDR_W-1:OFS_W]`. While that load lasts, a byte whose page field differs is ignored and does not restart the load timer.
- R4: Slots (`addr[OFS_W-1:0]`) may be loaded in any order. A slot loaded twice keeps the newest byte.
- R5: Programming starts, and `busy` rises, exactly `LOAD_TMO` cycles after the clock that accepted the last byte, provided no further byte of the open page arrives.
- R6: `busy` stays high for exactly `PROG_CYC` cycles. At the end, only the flagged slots of the open page are written, and all other array bytes are unchanged.
- R7: Write strobes that start or end while `busy` is high are ignored.
- R8: A clock with `ce_n`=0, `oe_n`=0 and `we_n`=1 gives `dout_en`=1 and `dout`=array[`addr`] after that clock. Any other strobe combination gives `dout_en`=0 after that clock.
- R9: After reset, `busy`=0, `dout_en`=0 and every array byte reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Byte address (page field above slot field) |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data |
| dout_en | output | 1 | Read data valid |
| busy | output | 1 | Programming period in progress |

## Verification
The bench sweeps every page of a small configuration. In each sweep it loads a permuted subset of slots, reloads some slots, and slips a foreign-page byte into one load. After each period it reads back the whole array, so a design that programmed unflagged slots, merged the foreign byte, or kept the first of two reloaded values shows a mismatch somewhere in the readback. It pins the start of `busy` to the exact cycle and measures how long it stays high, which catches timers that are off by one. Separate cases cover a strobe whose address and data move while it is active, strobes gated by output enable or chip select, and writes attempted during programming. A design that latched at the wrong edge, or accepted an inhibited or busy-time strobe, would either corrupt a byte or raise `busy` when it should not.

// File: rtl/pagewr_engine.sv
module pagewr_engine #(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 8,
  parameter int OFS_W    = 7,
  parameter int LOAD_TMO = 64,
  parameter int PROG_CYC = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              busy
);
  localparam int PG_W    = ADDR_W - OFS_W;
  localparam int PAGE_SZ = 1 << OFS_W;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int TMO_W   = $clog2(LOAD_TMO + 1);
  localparam int PRG_W   = $clog2(PROG_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_PROG} st_t;

  st_t st;
  logic              wr_act, wr_act_q, strb_ok;
  logic [ADDR_W-1:0] adr_lat;
  logic [DATA_W-1:0] din_q;
  logic [PG_W-1:0]   open_pg;
  logic [PAGE_SZ-1:0] vld;
  logic [DATA_W-1:0] pbuf [PAGE_SZ];
  logic [DATA_W-1:0] mem  [DEPTH];
  logic [TMO_W-1:0]  tmr;
  logic [PRG_W-1:0]  prg;

  assign wr_act = ~ce_n & ~we_n & oe_n;
  assign busy   = (st == S_PROG);

  wire strb_start = wr_act & ~wr_act_q;
  wire strb_end   = wr_act_q & ~wr_act;
  wire take       = strb_end & strb_ok & oe_n & ~busy;
  wire [PG_W-1:0]  lat_pg  = adr_lat[ADDR_W-1:OFS_W];
  wire [OFS_W-1:0] lat_ofs = adr_lat[OFS_W-1:0];
  wire open_new   = take & (st == S_IDLE);
  wire merge      = take & (st == S_LOAD) & (lat_pg == open_pg);
  wire tmo_hit    = (st == S_LOAD) & ~merge & (tmr == TMO_W'(LOAD_TMO - 1));
  wire prog_last  = busy & (prg == PRG_W'(PROG_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_act_q <= 1'b0;
      strb_ok  <= 1'b0;
      adr_lat  <= '0;
      din_q    <= '0;
    end else begin
      wr_act_q <= wr_act;
      din_q    <= din;
      if (strb_start) begin
        adr_lat <= addr;
        strb_ok <= ~busy;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      tmr     <= '0;
      prg     <= '0;
      open_pg <= '0;
    end else begin
      case (st)
        S_IDLE: if (open_new) begin
          st      <= S_LOAD;
          open_pg <= lat_pg;
          tmr     <= '0;
        end
        S_LOAD: begin
          if (merge) tmr <= '0;
          else if (tmo_hit) begin
            st  <= S_PROG;
            prg <= '0;
            tmr <= '0;
          end else tmr <= tmr + 1'b1;
        end
        S_PROG: begin
          prg <= prg + 1'b1;
          if (prog_last) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vld <= '0;
    else if (prog_last) vld <= '0;
    else if (open_new) vld <= PAGE_SZ'(1) << lat_ofs;
    else if (merge) vld[lat_ofs] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (open_new || merge) pbuf[lat_ofs] <= din_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (prog_last) begin
      for (int i = 0; i < PAGE_SZ; i++)
        if (vld[i]) mem[{open_pg, OFS_W'(i)}] <= pbuf[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout    <= '0;
      dout_en <= 1'b0;
    end else begin
      dout_en <= ~ce_n & ~oe_n & we_n;
      if (~ce_n & ~oe_n & we_n) dout <= mem[addr];
    end
  end
endmodule

// File: rtl/pagewr_engine_chk.sv
module pagewr_engine_chk #(
  parameter int OFS_W    = 7,
  parameter int PG_W     = 3,
  parameter int TMO_W    = 7,
  parameter int LOAD_TMO = 64,
  parameter int PROG_CYC = 256
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ce_n,
  input logic                  oe_n,
  input logic                  we_n,
  input logic                  busy,
  input logic                  dout_en,
  input logic                  take,
  input logic [(1<<OFS_W)-1:0] vld,
  input logic [PG_W-1:0]       open_pg,
  input logic [TMO_W-1:0]      tmr
);
  int bcnt;
  always_ff @(posedge clk) begin
    if (!rst_n) bcnt <= 0;
    else if (busy) bcnt <= bcnt + 1;
    else bcnt <= 0;
  end

  AST_READ_OFF: assert property (@(posedge clk) disable iff (!rst_n) (ce_n || oe_n || !we_n) |=> !dout_en); // R8
  AST_READ_ON: assert property (@(posedge clk) disable iff (!rst_n) (!ce_n && !oe_n && we_n) |=> dout_en); // R8
  AST_OE_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n) (!oe_n && !busy) |=> $stable(vld)); // R2
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (vld != 0 && $past(vld) != 0) |-> $stable(open_pg)); // R3
  AST_TAKE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) take |=> vld != 0); // R4
  AST_TMO_RANGE: assert property (@(posedge clk) disable iff (!rst_n) tmr < TMO_W'(LOAD_TMO)); // R5
  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> bcnt == PROG_CYC); // R6
  AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> $stable(vld)); // R7
endmodule

bind pagewr_engine pagewr_engine_chk #(
  .OFS_W(OFS_W), .PG_W(PG_W), .TMO_W(TMO_W), .LOAD_TMO(LOAD_TMO), .PROG_CYC(PROG_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .busy(busy),
  .dout_en(dout_en), .take(take), .vld(vld), .open_pg(open_pg), .tmr(tmr)
);

// File: tb/pagewr_engine_tb.sv
module pagewr_engine_tb;
  localparam int CLK_NS   = 10;
  localparam int ADDR_W   = 6;
  localparam int OFS_W    = 3;
  localparam int LOAD_TMO = 12;
  localparam int PROG_CYC = 30;
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int NPG      = 1 << (ADDR_W - OFS_W);

  logic clk = 0, rst_n = 0, ce_n = 1, oe_n = 1, we_n = 1;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] din = '0, dout;
  logic dout_en, busy;
  int n_cmp = 0, n_bad = 0;
  logic [7:0] model [DEPTH];
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  pagewr_engine #(.ADDR_W(ADDR_W), .DATA_W(8), .OFS_W(OFS_W), .LOAD_TMO(LOAD_TMO), .PROG_CYC(PROG_CYC))
    u_dut (.clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
           .din(din), .dout(dout), .dout_en(dout_en), .busy(busy));

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic strobe(input int a, input int d, input logic oe);
    @(negedge clk); addr = ADDR_W'(a); din = 8'(d); ce_n = 0; oe_n = oe;
    @(negedge clk); we_n = 0;
    @(negedge clk);
    @(negedge clk); we_n = 1; ce_n = 1; oe_n = 1;
    @(negedge clk);
  endtask

  task automatic rd(input int a, output int d, output int en);
    @(negedge clk); addr = ADDR_W'(a); ce_n = 0; oe_n = 0; we_n = 1;
    @(negedge clk); d = dout; en = dout_en; ce_n = 1; oe_n = 1;
  endtask

  task automatic settle();
    repeat (LOAD_TMO + PROG_CYC + 6) @(negedge clk);
  endtask

  task automatic sweep_read(input string tag);
    int d, en;
    for (int a = 0; a < DEPTH; a++) begin
      rd(a, d, en);
      check(tag, d, model[a]);
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int d, en, bl, pend_ofs [8], pend_dat [8];
    for (int a = 0; a < DEPTH; a++) model[a] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9 busy after reset", busy, 0);
    check("R9 dout_en after reset", dout_en, 0);
    sweep_read("R9 array zero");

    @(negedge clk); ce_n = 0; oe_n = 1; we_n = 1;
    @(negedge clk); check("R8 dout_en with oe_n high", dout_en, 0); ce_n = 1;
    rd(5, d, en); check("R8 dout_en on read", en, 1);

    for (int p = 0; p < NPG; p++) begin
      for (int k = 0; k < 8; k++) begin
        int o, v;
        o = (k * 5 + p) & 7;
        v = (p * 16 + o * 3 + 1) & 8'hff;
        if (((p + o) % 3) == 0) continue;
        if ((p % 2) == 0 && k == 1) begin
          strobe(p * 8 + o, v ^ 8'hff, 1);
        end
        strobe(p * 8 + o, v, 1);
        model[p * 8 + o] = 8'(v);
        if (p == 3 && k == 2) strobe(((p + 1) % NPG) * 8 + 1, 8'hee, 1);
      end
      repeat (LOAD_TMO - 1) @(negedge clk);
      check("R5 busy not yet", busy, 0);
      @(negedge clk);
      check("R5 busy at timeout", busy, 1);
      if (p % 2 == 0) begin
        bl = 0;
        while (busy && bl < PROG_CYC * 4) begin bl++; @(negedge clk); end
        check("R6 busy length", bl, PROG_CYC);
      end else begin
        strobe(p * 8 + 2, 8'h77, 1);
        check("R7 still busy", busy, 1);
        settle();
        check("R7 no new load", busy, 0);
      end
      sweep_read("R6 R4 R3 readback");
    end

    strobe(9, 8'h5a, 0);
    repeat (LOAD_TMO + 3) @(negedge clk);
    check("R2 oe low no busy", busy, 0);
    @(negedge clk); addr = 6'd10; din = 8'h3c; ce_n = 1; oe_n = 1;
    @(negedge clk); we_n = 0;
    @(negedge clk);
    @(negedge clk); we_n = 1;
    repeat (LOAD_TMO + 3) @(negedge clk);
    check("R2 ce high no busy", busy, 0);
    rd(9, d, en);  check("R2 oe-gated byte", d, model[9]);
    rd(10, d, en); check("R2 ce-gated byte", d, model[10]);

    @(negedge clk); we_n = 0; ce_n = 1; oe_n = 1; addr = 6'd17; din = 8'h11;
    @(negedge clk); addr = 6'd18; ce_n = 0;
    @(negedge clk); addr = 6'd21; din = 8'h22;
    @(negedge clk); din = 8'h33;
    @(negedge clk); ce_n = 1; din = 8'h44;
    @(negedge clk); we_n = 1;
    model[18] = 8'h33;
    settle();
    rd(18, d, en); check("R1 address at start, data at end", d, 8'h33);
    rd(21, d, en); check("R1 later address untouched", d, model[21]);
    rd(17, d, en); check("R1 earlier address untouched", d, model[17]);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule